// File: doc/BRIEF.md
# Static Memory Bus Timing Controller

This block connects a simple host request port to an external asynchronous bus for static memory or memory-mapped peripherals. The bus has four chip-select banks. The host gives a bank number, a word offset within that bank, a direction and write data. The block then runs one bus access and drives the address bus, one active-low select line per bank, an active-low read strobe and an active-low write strobe. The bidirectional data bus is modelled as separate input, output and output-enable signals.

Each bank has its own static configuration inputs:

- six cycle counts that shape the access;
- a data-width bit (one or two bytes);
- a page-read enable.

An access runs through these phases in order:

1. address setup;
2. select setup;
3. strobe;
4. select hold;
5. address hold.

A read to a bank with page reads enabled keeps the strobe low for four back-to-back beats, stepping the low address bits at each beat.

Every captured read word comes back on a one-cycle valid pulse. A one-cycle done pulse ends the access. The host may only issue a request while the block reports ready. The configuration of the addressed bank is latched when the request is accepted.

Top module: `smc_ctrl`

## Requirements
- R1: While reset is held and after it is released: ready is high, all bank selects are high, both strobes are high, the data bus output enable is low, and done and read-valid are low.
- R2: Timing and phase order of an access, where the fields are packed per bank b at bits [4b+3:4b], or [5b+4:5b] for the access count:
  - after acceptance, the address is driven with no select for `as` cycles;
  - the select is low for `cs` cycles before the strobe;
  - the strobe is low for `acc`+1 cycles;
  - the select stays low for `ch` cycles after the strobe rises;
  - `ah` cycles with the select released follow before done.
- R3: A setup or hold count of 0 adds no cycle. An access count of 0 still gives a one-cycle strobe.
- R4: At most one select is low at any time, and it is bit `bank` of the select bus, the one requested.
- R5: Outside page beats, the address bus equals the requested offset from the first cycle after acceptance until done.
- R6: Read data is sampled on the last strobe cycle of each beat. It appears on `rd_data` with a one-cycle `rd_valid` pulse in the next cycle.
- R7: A bank whose width bit is 0 uses only data bits [7:0]. Read data bits above 7 are returned as zero, and write data bits above 7 are driven as zero.
- R8: A read to a bank with its page bit set returns 4 beats under one continuous strobe.
  - The first beat lasts `acc`+1 cycles and each later beat lasts `pg`+1 cycles.
  - Each later beat adds 1 modulo 4 to address bits [1:0] and keeps the upper bits.
- R9: The page bit has no effect on writes: a write is one beat of `acc`+1 cycles.
- R10: On a write the write strobe is used and the read strobe stays high. The data bus output enable is high, with the write data on the bus, from the first address setup cycle through the last address hold cycle, and low otherwise.
- R11: Ready is high only when idle. Done is high for exactly one cycle after the address hold phase, and ready returns in the next cycle.
- R12: A bank configuration change after a request is accepted does not alter that access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Block idle, request accepted on this edge if valid |
| req_bank | input | BW | Target bank |
| req_addr | input | AW | Word offset within the bank |
| req_write | input | 1 | 1 write, 0 read |
| req_wdata | input | DW | Write data |
| rd_valid | output | 1 | One-cycle pulse per returned read word |
| rd_data | output | DW | Returned read word |
| done | output | 1 | One-cycle access completion pulse |
| bank_pg | input | 4*NB | Page beat count per bank |
| bank_ah | input | 4*NB | Address hold count per bank |
| bank_ch | input | 4*NB | Select hold count per bank |
| bank_acc | input | 5*NB | Access count per bank |
| bank_cs | input | 4*NB | Select setup count per bank |
| bank_as | input | 4*NB | Address setup count per bank |
| bank_wide | input | NB | 1 two-byte bus, 0 one-byte bus |
| bank_page | input | NB | Page read enable |
| mem_addr | output | AW | External address |
| mem_cs_n | output | NB | Active-low bank selects |
| mem_oe_n | output | 1 | Active-low read strobe |
| mem_we_n | output | 1 | Active-low write strobe |
| mem_dq_in | input | DW | Data bus in |
| mem_dq_out | output | DW | Data bus out |
| mem_dq_oe | output | 1 | Data bus output enable |

## Verification
The bound checker watches bus-level safety on every cycle:

- at most one select is low;
- the two strobes are never low together;
- a strobe is never low without a select;
- the data bus is never driven while the read strobe is low;
- done is a lone pulse followed by ready;
- every read-valid follows a read strobe cycle.

Only the bench scenarios can show the exact phase lengths for each configuration and the skipping of zero phases. The same holds for the page-beat address stepping and the data from each beat, for narrow-lane masking, and for configuration being latched at acceptance. The bench measures these at the ports against a memory model whose data is valid only while the read strobe is low.

// File: rtl/smc_pkg.sv
package smc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ASET,
        ST_CSET,
        ST_ACC,
        ST_PAGE,
        ST_CHOLD,
        ST_AHOLD,
        ST_DONE
    } smc_state_e;

    typedef struct packed {
        logic [3:0] pg;
        logic [3:0] ah;
        logic [3:0] ch;
        logic [4:0] acc;
        logic [3:0] cs;
        logic [3:0] as;
        logic       wide;
        logic       page;
    } smc_cfg_t;

endpackage

// File: rtl/smc_cfg_sel.sv
module smc_cfg_sel
    import smc_pkg::*;
#(
    parameter int NB = 4,
    parameter int BW = $clog2(NB)
) (
    input  logic [BW-1:0]   bank,
    input  logic [4*NB-1:0] bank_pg,
    input  logic [4*NB-1:0] bank_ah,
    input  logic [4*NB-1:0] bank_ch,
    input  logic [5*NB-1:0] bank_acc,
    input  logic [4*NB-1:0] bank_cs,
    input  logic [4*NB-1:0] bank_as,
    input  logic [NB-1:0]   bank_wide,
    input  logic [NB-1:0]   bank_page,
    output smc_cfg_t        cfg
);

    always_comb begin
        cfg.pg   = bank_pg [4*bank +: 4];
        cfg.ah   = bank_ah [4*bank +: 4];
        cfg.ch   = bank_ch [4*bank +: 4];
        cfg.acc  = bank_acc[5*bank +: 5];
        cfg.cs   = bank_cs [4*bank +: 4];
        cfg.as   = bank_as [4*bank +: 4];
        cfg.wide = bank_wide[bank];
        cfg.page = bank_page[bank];
    end

endmodule

// File: rtl/smc_cs_decode.sv
module smc_cs_decode #(
    parameter int NB = 4,
    parameter int BW = $clog2(NB)
) (
    input  logic          en,
    input  logic [BW-1:0] bank,
    output logic [NB-1:0] cs_n
);

    for (genvar g = 0; g < NB; g++) begin : g_sel
        assign cs_n[g] = !(en && (bank == BW'(g)));
    end

endmodule

// File: rtl/smc_ctrl.sv
module smc_ctrl
    import smc_pkg::*;
#(
    parameter int NB = 4,
    parameter int BW = $clog2(NB),
    parameter int AW = 16,
    parameter int DW = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    output logic            req_ready,
    input  logic [BW-1:0]   req_bank,
    input  logic [AW-1:0]   req_addr,
    input  logic            req_write,
    input  logic [DW-1:0]   req_wdata,
    output logic            rd_valid,
    output logic [DW-1:0]   rd_data,
    output logic            done,
    input  logic [4*NB-1:0] bank_pg,
    input  logic [4*NB-1:0] bank_ah,
    input  logic [4*NB-1:0] bank_ch,
    input  logic [5*NB-1:0] bank_acc,
    input  logic [4*NB-1:0] bank_cs,
    input  logic [4*NB-1:0] bank_as,
    input  logic [NB-1:0]   bank_wide,
    input  logic [NB-1:0]   bank_page,
    output logic [AW-1:0]   mem_addr,
    output logic [NB-1:0]   mem_cs_n,
    output logic            mem_oe_n,
    output logic            mem_we_n,
    input  logic [DW-1:0]   mem_dq_in,
    output logic [DW-1:0]   mem_dq_out,
    output logic            mem_dq_oe
);

    localparam int          CW          = 5;
    localparam logic [DW-1:0] NARROW_MASK = DW'(8'hFF);
    localparam logic [1:0]  LAST_BEAT   = 2'd3;

    typedef struct packed {
        smc_state_e    state;
        logic [CW-1:0] cnt;
        logic [1:0]    beat;
        smc_cfg_t      cfg;
        logic [BW-1:0] bank;
        logic [AW-1:0] addr;
        logic          write;
        logic [DW-1:0] wdata;
        logic          rd_valid;
        logic [DW-1:0] rd_data;
    } regs_t;

    regs_t    r_q, r_d;
    smc_cfg_t sel_cfg;
    logic     strobe, cs_en, bus_busy;

    smc_cfg_sel #(.NB(NB), .BW(BW)) u_cfg (
        .bank      (req_bank),
        .bank_pg   (bank_pg),
        .bank_ah   (bank_ah),
        .bank_ch   (bank_ch),
        .bank_acc  (bank_acc),
        .bank_cs   (bank_cs),
        .bank_as   (bank_as),
        .bank_wide (bank_wide),
        .bank_page (bank_page),
        .cfg       (sel_cfg)
    );

    always_comb begin
        r_d          = r_q;
        r_d.rd_valid = 1'b0;
        unique case (r_q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    r_d.cfg   = sel_cfg;
                    r_d.bank  = req_bank;
                    r_d.addr  = req_addr;
                    r_d.write = req_write;
                    r_d.wdata = sel_cfg.wide ? req_wdata : (req_wdata & NARROW_MASK);
                    r_d.beat  = 2'd0;
                    if (sel_cfg.as != 4'd0) begin
                        r_d.state = ST_ASET;
                        r_d.cnt   = {1'b0, sel_cfg.as} - 5'd1;
                    end else if (sel_cfg.cs != 4'd0) begin
                        r_d.state = ST_CSET;
                        r_d.cnt   = {1'b0, sel_cfg.cs} - 5'd1;
                    end else begin
                        r_d.state = ST_ACC;
                        r_d.cnt   = sel_cfg.acc;
                    end
                end
            end
            ST_ASET: begin
                if (r_q.cnt != '0) begin
                    r_d.cnt = r_q.cnt - 5'd1;
                end else if (r_q.cfg.cs != 4'd0) begin
                    r_d.state = ST_CSET;
                    r_d.cnt   = {1'b0, r_q.cfg.cs} - 5'd1;
                end else begin
                    r_d.state = ST_ACC;
                    r_d.cnt   = r_q.cfg.acc;
                end
            end
            ST_CSET: begin
                if (r_q.cnt != '0) begin
                    r_d.cnt = r_q.cnt - 5'd1;
                end else begin
                    r_d.state = ST_ACC;
                    r_d.cnt   = r_q.cfg.acc;
                end
            end
            ST_ACC, ST_PAGE: begin
                if (r_q.cnt != '0) begin
                    r_d.cnt = r_q.cnt - 5'd1;
                end else begin
                    if (!r_q.write) begin
                        r_d.rd_valid = 1'b1;
                        r_d.rd_data  = r_q.cfg.wide ? mem_dq_in : (mem_dq_in & NARROW_MASK);
                    end
                    if (r_q.cfg.page && !r_q.write && r_q.beat != LAST_BEAT) begin
                        r_d.state     = ST_PAGE;
                        r_d.beat      = r_q.beat + 2'd1;
                        r_d.addr[1:0] = r_q.addr[1:0] + 2'd1;
                        r_d.cnt       = {1'b0, r_q.cfg.pg};
                    end else if (r_q.cfg.ch != 4'd0) begin
                        r_d.state = ST_CHOLD;
                        r_d.cnt   = {1'b0, r_q.cfg.ch} - 5'd1;
                    end else if (r_q.cfg.ah != 4'd0) begin
                        r_d.state = ST_AHOLD;
                        r_d.cnt   = {1'b0, r_q.cfg.ah} - 5'd1;
                    end else begin
                        r_d.state = ST_DONE;
                    end
                end
            end
            ST_CHOLD: begin
                if (r_q.cnt != '0) begin
                    r_d.cnt = r_q.cnt - 5'd1;
                end else if (r_q.cfg.ah != 4'd0) begin
                    r_d.state = ST_AHOLD;
                    r_d.cnt   = {1'b0, r_q.cfg.ah} - 5'd1;
                end else begin
                    r_d.state = ST_DONE;
                end
            end
            ST_AHOLD: begin
                if (r_q.cnt != '0) r_d.cnt = r_q.cnt - 5'd1;
                else               r_d.state = ST_DONE;
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.state <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign strobe   = (r_q.state == ST_ACC) || (r_q.state == ST_PAGE);
    assign cs_en    = strobe || (r_q.state == ST_CSET) || (r_q.state == ST_CHOLD);
    assign bus_busy = (r_q.state != ST_IDLE) && (r_q.state != ST_DONE);

    smc_cs_decode #(.NB(NB), .BW(BW)) u_cs (
        .en   (cs_en),
        .bank (r_q.bank),
        .cs_n (mem_cs_n)
    );

    assign req_ready  = (r_q.state == ST_IDLE);
    assign done       = (r_q.state == ST_DONE);
    assign rd_valid   = r_q.rd_valid;
    assign rd_data    = r_q.rd_data;
    assign mem_addr   = r_q.addr;
    assign mem_oe_n   = !(strobe && !r_q.write);
    assign mem_we_n   = !(strobe && r_q.write);
    assign mem_dq_out = r_q.wdata;
    assign mem_dq_oe  = bus_busy && r_q.write;

endmodule

// File: rtl/smc_ctrl_chk.sv
module smc_ctrl_chk #(
    parameter int NB = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_ready,
    input logic          done,
    input logic          rd_valid,
    input logic [NB-1:0] mem_cs_n,
    input logic          mem_oe_n,
    input logic          mem_we_n,
    input logic          mem_dq_oe
);

    // R4
    cs_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~mem_cs_n));

    // R10
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!mem_oe_n && !mem_we_n));

    // R2
    strobe_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_oe_n || !mem_we_n) |-> (mem_cs_n != '1));

    // R10
    bus_turn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> mem_oe_n);

    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && req_ready));

    // R11
    busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_oe_n || !mem_we_n) |-> !req_ready);

    // R6
    rdv_after_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(!mem_oe_n));

endmodule

bind smc_ctrl smc_ctrl_chk #(.NB(NB)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .done      (done),
    .rd_valid  (rd_valid),
    .mem_cs_n  (mem_cs_n),
    .mem_oe_n  (mem_oe_n),
    .mem_we_n  (mem_we_n),
    .mem_dq_oe (mem_dq_oe)
);

// File: tb/sim_smc_ctrl.sv
module sim_smc_ctrl;

    localparam int NB = 4;
    localparam int BW = 2;
    localparam int AW = 16;
    localparam int DW = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic            req_valid = 1'b0;
    logic            req_ready;
    logic [BW-1:0]   req_bank = '0;
    logic [AW-1:0]   req_addr = '0;
    logic            req_write = 1'b0;
    logic [DW-1:0]   req_wdata = '0;
    logic            rd_valid, done;
    logic [DW-1:0]   rd_data;
    logic [4*NB-1:0] bank_pg, bank_ah, bank_ch, bank_cs, bank_as;
    logic [5*NB-1:0] bank_acc;
    logic [NB-1:0]   bank_wide, bank_page;
    logic [AW-1:0]   mem_addr;
    logic [NB-1:0]   mem_cs_n;
    logic            mem_oe_n, mem_we_n, mem_dq_oe;
    logic [DW-1:0]   mem_dq_in, mem_dq_out;

    int t_pg[NB], t_ah[NB], t_ch[NB], t_acc[NB], t_cs[NB], t_as[NB];
    bit t_wide[NB], t_page[NB];

    always_comb begin
        for (int b = 0; b < NB; b++) begin
            bank_pg [4*b +: 4] = 4'(t_pg[b]);
            bank_ah [4*b +: 4] = 4'(t_ah[b]);
            bank_ch [4*b +: 4] = 4'(t_ch[b]);
            bank_acc[5*b +: 5] = 5'(t_acc[b]);
            bank_cs [4*b +: 4] = 4'(t_cs[b]);
            bank_as [4*b +: 4] = 4'(t_as[b]);
            bank_wide[b]       = t_wide[b];
            bank_page[b]       = t_page[b];
        end
    end

    smc_ctrl #(.NB(NB), .BW(BW), .AW(AW), .DW(DW)) u0 (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_bank(req_bank),
        .req_addr(req_addr), .req_write(req_write), .req_wdata(req_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data), .done(done),
        .bank_pg(bank_pg), .bank_ah(bank_ah), .bank_ch(bank_ch), .bank_acc(bank_acc),
        .bank_cs(bank_cs), .bank_as(bank_as), .bank_wide(bank_wide), .bank_page(bank_page),
        .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
        .mem_dq_in(mem_dq_in), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe)
    );

    function automatic logic [DW-1:0] pat(int b, logic [AW-1:0] a);
        return {4'(b) + 4'h3, a[3:0] ^ 4'h5, a[7:0] ^ 8'h3C};
    endfunction

    // memory model: data valid only while read strobe is low
    always_comb begin
        mem_dq_in = 16'hDEAD;
        if (!mem_oe_n)
            for (int b = 0; b < NB; b++)
                if (!mem_cs_n[b]) mem_dq_in = pat(b, mem_addr);
    end

    int n_tot = 0, n_bad = 0, cyc = 0;
    logic [DW-1:0] exp_q[$];

    task automatic check(bit ok, string tag, longint act, longint exp);
        n_tot++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", n_tot, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 20000) begin
            n_tot++; n_bad++;
            $display("FAIL watchdog R11 actual=%0d expected=%0d", cyc, 0);
            finish_run();
        end
    end

    // scoreboard monitor: read words (R6, R8)
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            if (exp_q.size() == 0) check(1'b0, "R6 unexpected rd_valid", rd_data, 0);
            else begin
                logic [DW-1:0] e;
                e = exp_q.pop_front();
                check(rd_data == e, "R6/R8 read word", rd_data, e);
            end
        end
    end

    task automatic access(int b, logic [AW-1:0] a, bit wr, logic [DW-1:0] wd,
                          string tag, bit mod_cfg);
        int e_as, e_cs, e_st, e_ch, e_ah, n_as, n_cs, n_st, n_ch, n_ah, beats, guard;
        bit seen_st, bad_cs, bad_addr, bad_bus, bad_rdy, pg_rd;
        logic [DW-1:0] mask, e_wd;
        e_as = t_as[b]; e_cs = t_cs[b]; e_ch = t_ch[b]; e_ah = t_ah[b];
        pg_rd = t_page[b] && !wr;
        e_st  = t_acc[b] + 1 + (pg_rd ? 3 * (t_pg[b] + 1) : 0);
        mask  = t_wide[b] ? 16'hFFFF : 16'h00FF;
        e_wd  = wd & mask;
        beats = pg_rd ? 4 : 1;
        if (!wr)
            for (int k = 0; k < beats; k++) begin
                logic [AW-1:0] ak;
                ak = {a[AW-1:2], 2'(a[1:0] + 2'(k))};
                exp_q.push_back(pat(b, ak) & mask);
            end
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_bank = BW'(b); req_addr = a; req_write = wr; req_wdata = wd;
        @(posedge clk);
        #1 req_valid = 1'b0;
        n_as = 0; n_cs = 0; n_st = 0; n_ch = 0; n_ah = 0; guard = 0;
        seen_st = 0; bad_cs = 0; bad_addr = 0; bad_bus = 0; bad_rdy = 0;
        @(negedge clk);
        if (mod_cfg) begin
            t_as[b] = 7; t_cs[b] = 0; t_acc[b] = 9; t_ch[b] = 0; t_ah[b] = 5;
        end
        while (!done && guard < 400) begin
            bit strb;
            strb = wr ? !mem_we_n : !mem_oe_n;
            if (req_ready) bad_rdy = 1;
            if (mem_cs_n != '1) begin
                if (mem_cs_n != ~(NB'(1) << b)) bad_cs = 1;
                if (strb) begin n_st++; seen_st = 1; end
                else if (!seen_st) n_cs++;
                else n_ch++;
            end else begin
                if (strb) bad_cs = 1;
                if (!seen_st) n_as++; else n_ah++;
            end
            if (!pg_rd && mem_addr != a) bad_addr = 1;
            if (wr) begin
                if (!mem_dq_oe || mem_dq_out != e_wd || !mem_oe_n) bad_bus = 1;
            end else if (mem_dq_oe || !mem_we_n) bad_bus = 1;
            guard++;
            @(negedge clk);
        end
        check(n_as == e_as, {tag, " addr setup"}, n_as, e_as);
        check(n_cs == e_cs, {tag, " cs setup"}, n_cs, e_cs);
        check(n_st == e_st, {tag, " strobe len"}, n_st, e_st);
        check(n_ch == e_ch, {tag, " cs hold"}, n_ch, e_ch);
        check(n_ah == e_ah, {tag, " addr hold"}, n_ah, e_ah);
        check(!bad_cs, "R4 select decode", bad_cs, 0);
        check(!bad_rdy, "R11 ready low while busy", bad_rdy, 0);
        if (!pg_rd) check(!bad_addr, "R5 address stable", bad_addr, 0);
        check(!bad_bus, wr ? "R10 write bus drive" : "R10 bus idle on read", bad_bus, 0);
        check(done && !mem_dq_oe, "R10 bus released at done", mem_dq_oe, 0);
        @(negedge clk);
        check(req_ready && !done, "R11 done pulse then ready", {req_ready, done}, 2'b10);
    endtask

    initial begin
        t_as = '{0, 2, 1, 3};  t_cs = '{0, 1, 2, 1};  t_acc = '{0, 3, 2, 1};
        t_ch = '{0, 2, 1, 0};  t_ah = '{0, 1, 3, 2};  t_pg = '{0, 0, 1, 2};
        t_wide = '{1, 1, 1, 0}; t_page = '{0, 0, 1, 1};
        repeat (3) @(negedge clk);
        // R1 reset state
        check(req_ready && mem_cs_n == '1 && mem_oe_n && mem_we_n && !mem_dq_oe
              && !done && !rd_valid, "R1 reset outputs", {req_ready, mem_cs_n}, 5'h1F);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready && mem_cs_n == '1 && !mem_dq_oe, "R1 idle after reset",
              {req_ready, mem_cs_n}, 5'h1F);
        access(1, 16'h0123, 0, '0, "R2", 0);
        access(0, 16'h0040, 0, '0, "R3", 0);
        access(1, 16'h0456, 1, 16'hA55A, "R2 R10", 0);
        access(3, 16'h0777, 0, '0, "R7 R8", 0);
        access(3, 16'h0010, 1, 16'hBEEF, "R7 R9", 0);
        access(2, 16'h00F2, 0, '0, "R8", 0);
        access(2, 16'h0031, 1, 16'h1234, "R9", 0);
        access(1, 16'h0200, 0, '0, "R12", 1);
        access(1, 16'h0201, 0, '0, "R12 new cfg", 0);
        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R6 all read words returned", exp_q.size(), 0);
        finish_run();
    end

endmodule